// File: doc/BRIEF.md
# Clock-Recovery Ready Sequencer

This block sits between a token-ring protocol processor and the receive clock-recovery loop. It turns a set of initialization triggers into one ready handshake. The processor raises its frequency-acquisition request to make the loop restart. Lowering that request also restarts the loop. Releasing power-down and flipping the ring-speed select both restart it as well. Each restart sends a one-cycle reset pulse to the loop and keeps the active-low ready output deasserted for a fixed number of clock cycles. After that, ready returns low, which tells the processor that received data can be trusted again.

Ready is also withheld while the rate detector reports that the line carries no transitions. This gating works directly on the output and leaves the restart timer alone. Before the first restart completes after reset, ready stays deasserted. A device used standalone must therefore be initialized once by one of the triggers. Power-down release uses its own, longer restart window.

Top module: `lock_ready_seq`

## Requirements
- R1: After reset and before any initialization has completed, `ready_n` is 1 and `loop_rst` is 0.
- R2: A rising edge on `freq_acq` produces `loop_rst` high for exactly the cycle after the edge is sampled. `ready_n` is 1 from that cycle on and falls to 0 `INIT_CYCLES` clock edges after the pulse edge.
- R3: A falling edge on `freq_acq` starts the same initialization as R2, with the same pulse and the same timing.
- R4: Any change of `speed_sel`, from 0 to 1 or from 1 to 0, starts the same initialization as R2.
- R5: While `pwr_dn_n` is 0, `ready_n` is 1 and no pulse is issued. A rising edge on `pwr_dn_n` issues a pulse and holds `ready_n` at 1 for `PWRUP_CYCLES` edges after the pulse edge.
- R6: While `line_idle` is 1, `ready_n` is 1 in the same cycle, with no clock delay. `line_idle` issues no pulse and does not stop or restart the timer. Once the timer has finished and `line_idle` returns to 0, `ready_n` falls in that same cycle.
- R7: A trigger that arrives during an initialization issues a new pulse and restarts the full window from that trigger.
- R8: The input levels present when reset is released are not taken as edges. No pulse is issued until an input actually changes.
- R9: Changes of `freq_acq` or `speed_sel` while `pwr_dn_n` is 0 are ignored. They issue no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_acq | input | 1 | Frequency-acquisition request from the protocol processor; either edge restarts the loop |
| pwr_dn_n | input | 1 | Power-down, active low; release restarts the loop with the long window |
| speed_sel | input | 1 | Ring-speed select; any change restarts the loop |
| line_idle | input | 1 | High while the rate detector sees no line transitions |
| ready_n | output | 1 | Active-low ready; 0 means recovered data is valid |
| loop_rst | output | 1 | One-cycle reset pulse to the recovery loop |

## Verification
Each trigger is driven separately: an acquisition rise, an acquisition fall, speed flips in both directions, and power-down release. This shows that every trigger reaches the pulse and that the expected window length applies to each, including the longer power-up window. A second trigger is injected partway through a window to separate a restart from a window that simply continues. Line idle is raised both while ready is asserted and during a running window. This shows that it only masks the output and leaves the timer running. Inputs toggled during power-down, and a nonzero speed level at reset release, check that neither of those produces a pulse.

// File: rtl/lock_ready_seq.sv
module lock_ready_seq #(
  parameter int INIT_CYCLES  = 600,
  parameter int PWRUP_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freq_acq,
  input  logic pwr_dn_n,
  input  logic speed_sel,
  input  logic line_idle,
  output logic ready_n,
  output logic loop_rst
);
  localparam int MAXC = (PWRUP_CYCLES > INIT_CYCLES) ? PWRUP_CYCLES : INIT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          primed, acq_q, pd_q, spd_q, done;
  logic [CW-1:0] cnt;

  wire pd_rise    = primed & pwr_dn_n & ~pd_q;
  wire short_trig = primed & pwr_dn_n & pd_q &
                    ((freq_acq ^ acq_q) | (speed_sel ^ spd_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      acq_q    <= 1'b0;
      pd_q     <= 1'b1;
      spd_q    <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      loop_rst <= 1'b0;
    end else begin
      primed   <= 1'b1;
      acq_q    <= freq_acq;
      pd_q     <= pwr_dn_n;
      spd_q    <= speed_sel;
      loop_rst <= pd_rise | short_trig;
      if (!pwr_dn_n) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (pd_rise) begin
        cnt <= CW'(PWRUP_CYCLES);
      end else if (short_trig) begin
        cnt <= CW'(INIT_CYCLES);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign ready_n = ~(done & (cnt == '0) & pwr_dn_n & ~line_idle);
endmodule

module lock_ready_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic freq_acq,
  input logic pwr_dn_n,
  input logic speed_sel,
  input logic line_idle,
  input logic ready_n,
  input logic loop_rst
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  a_r2_acq_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pwr_dn_n && $past(pwr_dn_n) && freq_acq && !$past(freq_acq)) |=> loop_rst);
  a_r3_acq_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pwr_dn_n && $past(pwr_dn_n) && !freq_acq && $past(freq_acq)) |=> loop_rst);
  a_r4_speed_flip_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pwr_dn_n && $past(pwr_dn_n) && (speed_sel != $past(speed_sel))) |=> loop_rst);
  a_r5_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pwr_dn_n && !$past(pwr_dn_n)) |=> (loop_rst && ready_n));
  a_r5_down_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |-> ready_n);
  a_r9_down_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(pwr_dn_n)) |-> !loop_rst);
  a_r6_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> ready_n);
  a_r2_pulse_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    loop_rst |-> ready_n);
endmodule

bind lock_ready_seq lock_ready_seq_chk u_chk (.*);

// File: tb/lock_ready_seq_tb.sv
`timescale 1ns/100ps
module lock_ready_seq_tb;
  localparam int INIT  = 20;
  localparam int PWRUP = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic freq_acq = 1'b0, pwr_dn_n = 1'b1, speed_sel = 1'b1, line_idle = 1'b0;
  logic ready_n, loop_rst;

  lock_ready_seq #(.INIT_CYCLES(INIT), .PWRUP_CYCLES(PWRUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .freq_acq(freq_acq), .pwr_dn_n(pwr_dn_n),
    .speed_sel(speed_sel), .line_idle(line_idle), .ready_n(ready_n), .loop_rst(loop_rst));

  always #2.5 clk = ~clk;

  typedef struct { int kind; int at; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0, pulses = 0;
  string phase = "R8";
  logic prev_rdy = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int k, input int at, input string req);
    exp_t e;
    e.kind = k; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic cmp(input int k);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected event kind %0d at cycle %0d: actual event expected none", phase, k, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != k || e.at != cyc) begin
        fails++;
        $display("FAIL %s event: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 e.req, k, cyc, e.kind, e.at);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (loop_rst) begin pulses++; cmp(0); end
    if (prev_rdy && !ready_n) cmp(1);
    prev_rdy = ready_n;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int p0;
    step(5);
    rst_n = 1'b1;
    step(30);
    check(ready_n == 1'b1, "R1", ready_n, 1);
    check(loop_rst == 1'b0, "R1", loop_rst, 0);
    check(pulses == 0, "R8", pulses, 0);

    phase = "R2";
    push(0, cyc + 1, "R2"); push(1, cyc + 1 + INIT, "R2");
    freq_acq = 1'b1;
    step(10); check(ready_n == 1'b1, "R2", ready_n, 1);
    step(15); check(ready_n == 1'b0, "R2", ready_n, 0);

    phase = "R3";
    push(0, cyc + 1, "R3"); push(1, cyc + 1 + INIT, "R3");
    freq_acq = 1'b0;
    step(25); check(ready_n == 1'b0, "R3", ready_n, 0);

    phase = "R4";
    push(0, cyc + 1, "R4"); push(1, cyc + 1 + INIT, "R4");
    speed_sel = 1'b0;
    step(25); check(ready_n == 1'b0, "R4", ready_n, 0);
    push(0, cyc + 1, "R4"); push(1, cyc + 1 + INIT, "R4");
    speed_sel = 1'b1;
    step(25); check(ready_n == 1'b0, "R4", ready_n, 0);

    phase = "R7";
    push(0, cyc + 1, "R7");
    freq_acq = 1'b1;
    step(10);
    push(0, cyc + 1, "R7"); push(1, cyc + 1 + INIT, "R7");
    speed_sel = 1'b0;
    step(15); check(ready_n == 1'b1, "R7", ready_n, 1);
    step(10); check(ready_n == 1'b0, "R7", ready_n, 0);
    phase = "R3";
    push(0, cyc + 1, "R3"); push(1, cyc + 1 + INIT, "R3");
    freq_acq = 1'b0;
    step(25);

    phase = "R6";
    line_idle = 1'b1;
    #1 check(ready_n == 1'b1, "R6", ready_n, 1);
    step(8);
    check(ready_n == 1'b1, "R6", ready_n, 1);
    check(loop_rst == 1'b0, "R6", loop_rst, 0);
    push(1, cyc, "R6");
    line_idle = 1'b0;
    step(3); check(ready_n == 1'b0, "R6", ready_n, 0);
    push(0, cyc + 1, "R6");
    line_idle = 1'b1;
    speed_sel = 1'b1;
    step(25); check(ready_n == 1'b1, "R6", ready_n, 1);
    push(1, cyc, "R6");
    line_idle = 1'b0;
    step(2); check(ready_n == 1'b0, "R6", ready_n, 0);

    phase = "R9";
    p0 = pulses;
    pwr_dn_n = 1'b0;
    #1 check(ready_n == 1'b1, "R5", ready_n, 1);
    step(3); freq_acq = 1'b1;
    step(3); speed_sel = 1'b0;
    step(3); freq_acq = 1'b0;
    step(5);
    check(ready_n == 1'b1, "R9", ready_n, 1);
    check(pulses == p0, "R9", pulses, p0);
    phase = "R5";
    push(0, cyc + 1, "R5"); push(1, cyc + 1 + PWRUP, "R5");
    pwr_dn_n = 1'b1;
    step(30); check(ready_n == 1'b1, "R5", ready_n, 1);
    step(30); check(ready_n == 1'b0, "R5", ready_n, 0);

    step(5);
    check(q.size() == 0, "R2", q.size(), 0);
    summary();
  end
endmodule